// File: doc/BRIEF.md
# Whole-Cache Maintenance Controller with Dirty-Status Flag

This block runs whole-cache maintenance on the valid/dirty state of a small write-back data cache. Commands arrive on a register-style command port. Each command carries four selector fields (a major register number, a minor register number and two opcode fields) and a write/read strobe. A maintenance write starts one of three operations:

- A clean sweep. It writes back every dirty line and leaves the lines valid.
- A clean-and-invalidate sweep. It writes back dirty lines and drops every line's valid bit.
- An invalidate-all. It clears the whole array in one cycle with no write-back.

A sweep walks the lines in ascending index order. The line index is the set number above the way number. A clean line takes one cycle. A dirty line waits on a valid/ready write-back port.

The block also keeps a one-bit dirty-status flag that software reads through the command port. Any cache write sets the flag. Only a sweep that reaches its last line with no cache write seen since it started clears it. Software can therefore sweep with interrupts enabled, then mask interrupts and read the flag to learn whether the cache is really clean.

An interrupt input aborts a running sweep. On abort the block pulses an abort output and reports a restart offset of 4. Re-issuing the command restarts the sweep from set 0, way 0.

Top module: `cache_maint_ctrl`

## Requirements
- R1: After reset the controller is idle (busy low), every line is invalid and clean, and the dirty-status read returns 0.
- R2: A read (cmd_write=0) with major=7, minor=10, op2=6, op1=0 returns the flag in rd_data bit 0, with rd_valid high, one cycle after the command. Any other read returns 0.
- R3: A cache write on the cw port marks that line valid and dirty and sets the flag from the next cycle on.
- R4: A clean write (major=7, minor=10, op1=0, op2=0) issues one write-back per dirty line in ascending line order and no other write-back. The swept lines end valid and clean.
- R5: While wb_valid is high and wb_ready is low, wb_set and wb_way hold their values and the sweep does not advance.
- R6: A clean-and-invalidate write (minor=14, other fields as for clean) writes back the dirty lines and leaves every line invalid.
- R7: An invalidate-all write (minor=6, other fields as for clean) clears all valid and dirty bits and the flag in one cycle, with no write-back and without raising busy.
- R8: A completed sweep clears the flag only when no cache write occurred during it. A line written after it was swept stays dirty, and the flag then stays set.
- R9: An interrupt during a sweep drops busy on the next cycle and pulses abort_pulse with restart_ofs=4. The flag is left unchanged. A re-issued command sweeps again from line 0.
- R10: Maintenance writes received while busy are ignored.
- R11: busy rises the cycle after a sweep command. A sweep over a fully clean cache keeps busy high for exactly SETS*WAYS cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_write | input | 1 | 1 = register write, 0 = register read |
| cmd_op1 | input | 3 | First opcode field |
| cmd_crn | input | 4 | Major register number |
| cmd_crm | input | 4 | Minor register number |
| cmd_op2 | input | 3 | Second opcode field |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data; bit 0 is the flag for a status read |
| cw_en | input | 1 | Cache write into a line |
| cw_set | input | 3 | Set of the cache write |
| cw_way | input | 1 | Way of the cache write |
| irq | input | 1 | Interrupt; aborts a running sweep |
| busy | output | 1 | Sweep in progress |
| abort_pulse | output | 1 | One-cycle pulse after an abort |
| restart_ofs | output | 3 | Restart offset, 4 while abort_pulse is high |
| wb_valid | output | 1 | Write-back request |
| wb_ready | input | 1 | Write-back accepted |
| wb_set | output | 3 | Set of the line being written back |
| wb_way | output | 1 | Way of the line being written back |
| pr_set | input | 3 | Probe set |
| pr_way | input | 1 | Probe way |
| pr_valid | output | 1 | Valid bit of the probed line |
| pr_dirty | output | 1 | Dirty bit of the probed line |

## Verification
The sweep is driven under several patterns, and each pattern separates a different failure:

- Scattered dirty lines with a toggling wb_ready show whether ordering or stalls go wrong.
- An all-clean cache exposes any wrong per-line cycle count.
- A write to an already-swept line shows whether the flag is cleared wrongly at completion.
- An interrupt in the middle of a stall shows whether an abort clears the flag or loses the restart point.

Invalidate-all is applied both at idle and while busy, which tells a correct ignore apart from a command that leaks into a running sweep. Status reads are compared with other-register reads to confirm the decode.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
    typedef enum logic [2:0] {
        K_NONE,
        K_RD_STAT,
        K_RD_OTHER,
        K_CLEAN,
        K_CLEAN_INV,
        K_INV_ALL
    } cmc_kind_e;

    localparam logic [3:0] MAJ_MAINT  = 4'd7;
    localparam logic [3:0] MIN_CLEAN  = 4'd10;
    localparam logic [3:0] MIN_CINV   = 4'd14;
    localparam logic [3:0] MIN_INV    = 4'd6;
    localparam logic [2:0] OP2_STATUS = 3'd6;
endpackage

// File: rtl/cmc_decode.sv
module cmc_decode
    import cmc_pkg::*;
(
    input  logic       cmd_valid,
    input  logic       cmd_write,
    input  logic [2:0] cmd_op1,
    input  logic [3:0] cmd_crn,
    input  logic [3:0] cmd_crm,
    input  logic [2:0] cmd_op2,
    output cmc_kind_e  kind
);
    logic sel;

    always_comb begin
        sel  = (cmd_crn == MAJ_MAINT) && (cmd_op1 == 3'd0);
        kind = K_NONE;
        if (cmd_valid && !cmd_write) begin
            if (sel && cmd_crm == MIN_CLEAN && cmd_op2 == OP2_STATUS)
                kind = K_RD_STAT;
            else
                kind = K_RD_OTHER;
        end else if (cmd_valid && sel && cmd_op2 == 3'd0) begin
            case (cmd_crm)
                MIN_CLEAN: kind = K_CLEAN;
                MIN_CINV:  kind = K_CLEAN_INV;
                MIN_INV:   kind = K_INV_ALL;
                default:   kind = K_NONE;
            endcase
        end
    end
endmodule

// File: rtl/cmc_line_array.sv
module cmc_line_array #(
    parameter int LINES = 16,
    localparam int IW   = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic             sw_en,
    input  logic [IW-1:0]    sw_idx,
    input  logic             sw_inv,
    input  logic             inv_all,
    output logic [LINES-1:0] valid_q,
    output logic [LINES-1:0] dirty_q
);
    logic [LINES-1:0] valid_d, dirty_d;

    always_comb begin
        valid_d = valid_q;
        dirty_d = dirty_q;
        if (inv_all) begin
            valid_d = '0;
            dirty_d = '0;
        end
        if (sw_en) begin
            dirty_d[sw_idx] = 1'b0;
            if (sw_inv) valid_d[sw_idx] = 1'b0;
        end
        if (wr_en) begin
            valid_d[wr_idx] = 1'b1;
            dirty_d[wr_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            valid_q <= valid_d;
            dirty_q <= dirty_d;
        end
    end

    a_r7_inv_all_clears: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all && !wr_en |=> (valid_q == '0) && (dirty_q == '0));
endmodule

// File: rtl/cache_maint_ctrl.sv
module cache_maint_ctrl
    import cmc_pkg::*;
#(
    parameter int SETS        = 8,
    parameter int WAYS        = 2,
    parameter int DATA_W      = 32,
    parameter int RESTART_OFS = 4,
    localparam int SET_W      = $clog2(SETS),
    localparam int WAY_W      = $clog2(WAYS),
    localparam int LINES      = SETS * WAYS,
    localparam int IW         = SET_W + WAY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [2:0]        cmd_op1,
    input  logic [3:0]        cmd_crn,
    input  logic [3:0]        cmd_crm,
    input  logic [2:0]        cmd_op2,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              cw_en,
    input  logic [SET_W-1:0]  cw_set,
    input  logic [WAY_W-1:0]  cw_way,
    input  logic              irq,
    output logic              busy,
    output logic              abort_pulse,
    output logic [2:0]        restart_ofs,
    output logic              wb_valid,
    input  logic              wb_ready,
    output logic [SET_W-1:0]  wb_set,
    output logic [WAY_W-1:0]  wb_way,
    input  logic [SET_W-1:0]  pr_set,
    input  logic [WAY_W-1:0]  pr_way,
    output logic              pr_valid,
    output logic              pr_dirty
);
    typedef struct packed {
        logic          busy;
        logic          inv;
        logic [IW-1:0] idx;
        logic          seen;
        logic          flag;
        logic          rd_valid;
        logic          rd_bit;
        logic          abort;
    } ctl_t;

    ctl_t       st_q, st_d;
    cmc_kind_e  kind;
    logic [LINES-1:0] valid_vec, dirty_vec;
    logic       line_dirty, advance, last, inv_all;

    cmc_decode u_dec (
        .cmd_valid (cmd_valid),
        .cmd_write (cmd_write),
        .cmd_op1   (cmd_op1),
        .cmd_crn   (cmd_crn),
        .cmd_crm   (cmd_crm),
        .cmd_op2   (cmd_op2),
        .kind      (kind)
    );

    assign line_dirty = dirty_vec[st_q.idx];
    assign advance    = st_q.busy && !irq && (!line_dirty || wb_ready);
    assign last       = (st_q.idx == IW'(LINES - 1));
    assign inv_all    = !st_q.busy && (kind == K_INV_ALL);

    cmc_line_array #(.LINES(LINES)) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cw_en),
        .wr_idx  ({cw_set, cw_way}),
        .sw_en   (advance),
        .sw_idx  (st_q.idx),
        .sw_inv  (st_q.inv),
        .inv_all (inv_all),
        .valid_q (valid_vec),
        .dirty_q (dirty_vec)
    );

    always_comb begin
        st_d          = st_q;
        st_d.rd_valid = 1'b0;
        st_d.abort    = 1'b0;
        if (cmd_valid && !cmd_write) begin
            st_d.rd_valid = 1'b1;
            st_d.rd_bit   = (kind == K_RD_STAT) && st_q.flag;
        end
        if (st_q.busy) begin
            if (irq) begin
                st_d.busy  = 1'b0;
                st_d.abort = 1'b1;
            end else if (advance) begin
                if (last) begin
                    st_d.busy = 1'b0;
                    if (!st_q.seen) st_d.flag = 1'b0;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end
        end else begin
            case (kind)
                K_CLEAN, K_CLEAN_INV: begin
                    st_d.busy = 1'b1;
                    st_d.inv  = (kind == K_CLEAN_INV);
                    st_d.idx  = '0;
                    st_d.seen = 1'b0;
                end
                K_INV_ALL: st_d.flag = 1'b0;
                default: ;
            endcase
        end
        if (cw_en) begin
            st_d.flag = 1'b1;
            if (st_q.busy) st_d.seen = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy        = st_q.busy;
    assign rd_valid    = st_q.rd_valid;
    assign rd_data     = {{(DATA_W-1){1'b0}}, st_q.rd_bit};
    assign abort_pulse = st_q.abort;
    assign restart_ofs = st_q.abort ? 3'(RESTART_OFS) : 3'd0;
    assign wb_valid    = st_q.busy && line_dirty && !irq;
    assign wb_set      = st_q.idx[IW-1:WAY_W];
    assign wb_way      = st_q.idx[WAY_W-1:0];
    assign pr_valid    = valid_vec[{pr_set, pr_way}];
    assign pr_dirty    = dirty_vec[{pr_set, pr_way}];

    a_r3_write_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        cw_en |=> st_q.flag);

    a_r5_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && !wb_ready |=> $stable(wb_set) && $stable(wb_way));

    a_r9_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        busy && irq |=> !busy && abort_pulse);

    a_r9_abort_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
        busy && irq && st_q.flag |=> st_q.flag);
endmodule

// File: tb/cache_maint_ctrl_tb.sv
`timescale 1ns/1ps
module cache_maint_ctrl_tb;
    logic clk = 0, rst_n = 0;
    logic cmd_valid = 0, cmd_write = 0;
    logic [2:0] cmd_op1 = 0, cmd_op2 = 0;
    logic [3:0] cmd_crn = 0, cmd_crm = 0;
    logic rd_valid; logic [31:0] rd_data;
    logic cw_en = 0; logic [2:0] cw_set = 0; logic cw_way = 0;
    logic irq = 0, busy, abort_pulse; logic [2:0] restart_ofs;
    logic wb_valid, wb_ready = 0; logic [2:0] wb_set; logic wb_way;
    logic [2:0] pr_set = 0; logic pr_way = 0; logic pr_valid, pr_dirty;

    int checks = 0, fails = 0, rdy_mode = 0;
    logic [3:0] exp_q[$];

    always #4 clk = ~clk;

    cache_maint_ctrl u_dut (.*);

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    // ready pattern: 0 low, 1 high, 2 toggling
    always @(negedge clk)
        wb_ready <= (rdy_mode == 1) ? 1'b1 : (rdy_mode == 2) ? ~wb_ready : 1'b0;

    // monitor / scoreboard, sampled mid-cycle
    logic       stall_prev = 0;
    logic [3:0] stall_line = 0;
    always begin
        @(negedge clk); #2;
        if (rst_n) begin
            if (stall_prev && wb_valid) chk("R5 held line", {wb_set, wb_way}, stall_line);
            stall_prev = wb_valid && !wb_ready;
            stall_line = {wb_set, wb_way};
            if (wb_valid && wb_ready) begin
                if (exp_q.size() == 0) chk("R4 unexpected write-back", {wb_set, wb_way}, 99);
                else chk("R4 write-back order", {wb_set, wb_way}, exp_q.pop_front());
            end
        end
    end

    task automatic cmd(input bit wr, input [3:0] crm, input [2:0] op2);
        @(negedge clk);
        cmd_valid = 1; cmd_write = wr; cmd_crn = 7; cmd_op1 = 0; cmd_crm = crm; cmd_op2 = op2;
        @(negedge clk);
        cmd_valid = 0;
    endtask

    task automatic read_stat(string req, int exp, input [3:0] crm = 10, input [2:0] op2 = 6);
        cmd(0, crm, op2);
        chk({req, " rd_valid"}, rd_valid, 1);
        chk({req, " rd_data"}, int'(rd_data), exp);
    endtask

    task automatic cache_wr(input [2:0] s, input w);
        @(negedge clk); cw_en = 1; cw_set = s; cw_way = w;
        @(negedge clk); cw_en = 0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        #3;
    endtask

    task automatic probe(string req, input [2:0] s, input w, int v, int d);
        pr_set = s; pr_way = w; #1;
        chk({req, " valid"}, pr_valid, v);
        chk({req, " dirty"}, pr_dirty, d);
    endtask

    initial begin
        #(8 * 150000);
        chk("watchdog", 0, 1);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        probe("R1", 0, 0, 0, 0);
        probe("R1", 7, 1, 0, 0);
        read_stat("R1 status", 0);
        // R3 write sets flag; R2 other register reads 0
        cache_wr(0, 1); cache_wr(3, 0); cache_wr(7, 1);
        read_stat("R3 flag", 1);
        read_stat("R2 other reg", 0, 10, 5);
        probe("R3", 3, 0, 1, 1);
        // R4/R5 clean with toggling ready
        exp_q.push_back({3'd0, 1'b1}); exp_q.push_back({3'd3, 1'b0}); exp_q.push_back({3'd7, 1'b1});
        rdy_mode = 2;
        cmd(1, 10, 0);
        chk("R11 busy rises", busy, 1);
        wait_idle();
        chk("R4 queue drained", exp_q.size(), 0);
        probe("R4", 0, 1, 1, 0);
        probe("R4", 7, 1, 1, 0);
        read_stat("R8 cleared", 0);
        // R11 clean cache: LINES cycles
        begin
            int n = 0;
            cmd(1, 10, 0);
            while (busy) begin n++; @(negedge clk); end
            chk("R11 sweep cycles", n, 16);
        end
        // R8 write to swept line during sweep
        rdy_mode = 0;
        cache_wr(2, 0);
        exp_q.push_back({3'd2, 1'b0});
        cmd(1, 10, 0);
        while (!wb_valid) @(negedge clk);
        cache_wr(0, 0);
        // R10 invalidate-all while busy ignored
        cmd(1, 6, 0);
        rdy_mode = 1;
        wait_idle();
        read_stat("R8 flag kept", 1);
        probe("R8 late write", 0, 0, 1, 1);
        probe("R10 line kept", 2, 0, 1, 0);
        exp_q.push_back({3'd0, 1'b0});
        cmd(1, 10, 0);
        wait_idle();
        read_stat("R8 clean again", 0);
        // R9 abort
        rdy_mode = 0;
        cache_wr(5, 0);
        cmd(1, 10, 0);
        while (!wb_valid) @(negedge clk);
        irq = 1; @(negedge clk); irq = 0;
        #1;
        chk("R9 abort pulse", abort_pulse, 1);
        chk("R9 restart ofs", restart_ofs, 4);
        chk("R9 busy low", busy, 0);
        read_stat("R9 flag unchanged", 1);
        probe("R9 line still dirty", 5, 0, 1, 1);
        exp_q.push_back({3'd5, 1'b0});
        rdy_mode = 1;
        cmd(1, 10, 0);
        wait_idle();
        chk("R9 restart drained", exp_q.size(), 0);
        read_stat("R9 after restart", 0);
        // R6 clean-and-invalidate
        cache_wr(1, 1); cache_wr(6, 0);
        exp_q.push_back({3'd1, 1'b1}); exp_q.push_back({3'd6, 1'b0});
        rdy_mode = 2;
        cmd(1, 14, 0);
        wait_idle();
        chk("R6 queue drained", exp_q.size(), 0);
        probe("R6", 1, 1, 0, 0);
        probe("R6", 0, 1, 0, 0);
        read_stat("R6 status", 0);
        // R7 invalidate-all at idle
        cache_wr(4, 1); cache_wr(2, 0);
        cmd(1, 6, 0);
        chk("R7 no busy", busy, 0);
        probe("R7", 4, 1, 0, 0);
        probe("R7", 2, 0, 0, 0);
        read_stat("R7 status", 0);
        repeat (4) @(negedge clk);
        chk("R7 no write-back pending", exp_q.size(), 0);
        summary();
    end
endmodule